// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialization Scheduler

This block keeps an asynchronous DRAM alive. After reset it waits out the power-up settling pause. It then runs a fixed number of CAS-before-RAS refresh cycles, and only after that does it report the memory ready for host traffic. From then on a free-running interval counter grants one refresh credit per refresh slot, so that every internal row is covered inside the retention period. Each credit becomes one CAS-before-RAS cycle. In that cycle both column strobes fall before the row strobe, the device supplies the row from its own counter, and the address, write-enable, output-enable and data pins are left to the access controller as don't-care.

The scheduler does not own the memory pins permanently. It raises a request to the access controller and touches no strobe until the grant arrives. It keeps the request high until its cycle has fully precharged, and it marks the last cycle of that precharge with a one-cycle completion pulse. If grants are late, credits pile up in a saturating counter, so a short stall loses no refresh. A full counter is flagged as an error. A sleep request moves the memory into self-refresh: the row strobe and column strobes are held low for at least the minimum self-refresh time, and a long precharge follows on exit.

Every timing parameter is given in nanoseconds together with the clock period. Each is converted to a whole number of clock cycles by rounding up, with a floor of one cycle.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, and just after it is released, `req`, `done`, `init_done`, `debt_err` and `self_active` are 0, `ras_n` is 1 and `cas_n` is 2'b11. The first `req` rises exactly ceil(PAUSE_NS/CLK_NS) cycles after reset release.
- R2: Exactly INIT_CYCLES refresh cycles run before `init_done` rises. `init_done` rises in the cycle right after the last of their `done` pulses and never falls again. `sleep_req` has no effect until `init_done` is high.
- R3: In every refresh cycle both bits of `cas_n` go low ceil(CSR_NS/CLK_NS) cycles before `ras_n` falls. They stay low for the whole `ras_n` low time. For a normal refresh that time is ceil(RAS_NS/CLK_NS) cycles.
- R4: No strobe moves while `req` is high and `grant` is low. Once `ras_n` rises, it stays high for ceil(RP_NS/CLK_NS) cycles with `req` still high. `done` is a one-cycle pulse in the last of those cycles.
- R5: After `init_done`, one credit is added every ceil(REFI_NS/CLK_NS) cycles. With `grant` tied high, `req` rises at that exact spacing. The first rise comes ceil(REFI_NS/CLK_NS)+1 cycles after `init_done` rises.
- R6: Unserved credits accumulate up to CREDIT_MAX, and further credits are dropped. `debt_err` is high exactly while CREDIT_MAX credits are pending. When the grant returns, exactly CREDIT_MAX refresh cycles are served back to back.
- R7: When a credit is pending and `sleep_req` is high at the same time, the normal refresh cycle runs first, and self-refresh is entered after it.
- R8: In self-refresh, `self_active` is high and `ras_n` and both `cas_n` bits stay low for max(ceil(SELF_NS/CLK_NS), cycles until `sleep_req` is seen low) cycles.
- R9: On self-refresh exit, `req` stays high for ceil(SRP_NS/CLK_NS) cycles after `ras_n` rises. Pending credits are cleared and the interval restarts, so the next `req` rises ceil(REFI_NS/CLK_NS)+1 cycles after `req` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Access controller hands the memory pins to this block |
| sleep_req | input | 1 | Requests self-refresh while high |
| req | output | 1 | Asks for, and then holds, the memory pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Both column strobes, active low, always driven together |
| done | output | 1 | One-cycle pulse in the final precharge cycle of a refresh |
| init_done | output | 1 | Power-up sequence finished; host access allowed |
| debt_err | output | 1 | Pending refresh credits have reached the limit |
| self_active | output | 1 | Memory is held in self-refresh |

## Verification
Two events can land in the same cycle: a pending refresh credit and a sleep request. The bench creates this overlap by holding the grant low until a credit has raised the request. It then raises the sleep request and the grant together. It checks that the first row-strobe pulse is a normal refresh of the standard width with self-refresh inactive, and that the self-refresh pulse follows it. Debt saturation is checked the same way: the grant is withheld past one extra interval, and the bench then counts exactly the saturation limit of completions.

// File: rtl/dram_refresh_sched.sv
`timescale 1ns/1ps
module dram_refresh_sched #(
  parameter int CLK_NS      = 8,
  parameter int PAUSE_NS    = 200000,
  parameter int REFI_NS     = 15600,
  parameter int CSR_NS      = 5,
  parameter int RAS_NS      = 60,
  parameter int RP_NS       = 40,
  parameter int SELF_NS     = 100000,
  parameter int SRP_NS      = 105,
  parameter int INIT_CYCLES = 8,
  parameter int CREDIT_MAX  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       grant,
  input  logic       sleep_req,
  output logic       req,
  output logic       ras_n,
  output logic [1:0] cas_n,
  output logic       done,
  output logic       init_done,
  output logic       debt_err,
  output logic       self_active
);

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int PAUSE_CYC = to_cyc(PAUSE_NS);
  localparam int REFI_CYC  = to_cyc(REFI_NS);
  localparam int CSR_CYC   = to_cyc(CSR_NS);
  localparam int RAS_CYC   = to_cyc(RAS_NS);
  localparam int RP_CYC    = to_cyc(RP_NS);
  localparam int SELF_CYC  = to_cyc(SELF_NS);
  localparam int SRP_CYC   = to_cyc(SRP_NS);
  localparam int TMAX = mx(mx(mx(PAUSE_CYC, SELF_CYC), mx(RAS_CYC, RP_CYC)), mx(CSR_CYC, SRP_CYC));
  localparam int TW   = $clog2(TMAX + 1);
  localparam int IW   = $clog2(REFI_CYC + 1);
  localparam int CW   = $clog2(CREDIT_MAX + 1);
  localparam int NW   = $clog2(INIT_CYCLES + 1);

  typedef enum logic [2:0] {
    S_PAUSE, S_IDLE, S_REQ, S_CSR, S_RAS, S_PRE, S_SELF, S_SEXIT
  } st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [IW-1:0] ivl;
  logic [CW-1:0] credit;
  logic [NW-1:0] icnt;
  logic          slp;

  wire tmr_end = (tmr == '0);
  wire run     = init_done && !slp;
  wire tick    = run && (ivl == '0);
  wire served  = done && init_done;
  wire sx_end  = (st == S_SEXIT) && tmr_end;

  assign done        = (st == S_PRE) && tmr_end;
  assign req         = !(st inside {S_PAUSE, S_IDLE});
  assign ras_n       = !(st inside {S_RAS, S_SELF});
  assign cas_n       = {2{!(st inside {S_CSR, S_RAS, S_SELF})}};
  assign self_active = (st == S_SELF);
  assign debt_err    = (credit == CW'(CREDIT_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_PAUSE;
      tmr       <= TW'(PAUSE_CYC - 1);
      slp       <= 1'b0;
      init_done <= 1'b0;
      icnt      <= '0;
    end else begin
      case (st)
        S_PAUSE: if (tmr_end) st <= S_REQ; else tmr <= tmr - 1'b1;
        S_IDLE: begin
          if (!init_done || credit != '0) begin
            st <= S_REQ;
          end else if (sleep_req) begin
            st  <= S_REQ;
            slp <= 1'b1;
          end
        end
        S_REQ: if (grant) begin
          st  <= S_CSR;
          tmr <= TW'(CSR_CYC - 1);
        end
        S_CSR: begin
          if (tmr_end) begin
            st  <= slp ? S_SELF : S_RAS;
            tmr <= slp ? TW'(SELF_CYC - 1) : TW'(RAS_CYC - 1);
          end else tmr <= tmr - 1'b1;
        end
        S_RAS: begin
          if (tmr_end) begin
            st  <= S_PRE;
            tmr <= TW'(RP_CYC - 1);
          end else tmr <= tmr - 1'b1;
        end
        S_PRE: begin
          if (tmr_end) begin
            st <= S_IDLE;
            if (!init_done) begin
              icnt <= icnt + 1'b1;
              if (icnt == NW'(INIT_CYCLES - 1)) init_done <= 1'b1;
            end
          end else tmr <= tmr - 1'b1;
        end
        S_SELF: begin
          if (!tmr_end) tmr <= tmr - 1'b1;
          else if (!sleep_req) begin
            st  <= S_SEXIT;
            tmr <= TW'(SRP_CYC - 1);
          end
        end
        S_SEXIT: begin
          if (tmr_end) begin
            st  <= S_IDLE;
            slp <= 1'b0;
          end else tmr <= tmr - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl    <= IW'(REFI_CYC - 1);
      credit <= '0;
    end else begin
      if (!run || ivl == '0) ivl <= IW'(REFI_CYC - 1);
      else                   ivl <= ivl - 1'b1;
      if (sx_end)                                          credit <= '0;
      else if (tick && !served && credit != CW'(CREDIT_MAX)) credit <= credit + CW'(1);
      else if (!tick && served)                              credit <= credit - CW'(1);
    end
  end

endmodule

// File: rtl/dram_refresh_sched_chk.sv
`timescale 1ns/1ps
module dram_refresh_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic       ras_n,
  input logic [1:0] cas_n,
  input logic       done,
  input logic       init_done,
  input logic       debt_err,
  input logic       self_active,
  input int         min_pre,
  input int         min_self
);
  int hi_cnt;
  int lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= 0;
      lo_cnt <= 0;
    end else begin
      hi_cnt <= ras_n  ? ((hi_cnt < 1000000) ? hi_cnt + 1 : hi_cnt) : 0;
      lo_cnt <= !ras_n ? ((lo_cnt < 1000000) ? lo_cnt + 1 : lo_cnt) : 0;
    end
  end

  assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(cas_n) == 2'b00);
  assert_cas_covers_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> cas_n == 2'b00);
  assert_strobes_need_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || cas_n != 2'b11) |-> req);
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_precharge_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_cnt >= min_pre);
  assert_init_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  assert_no_sleep_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
    self_active |-> init_done);
  assert_debt_after_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
    debt_err |-> init_done);
  assert_self_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && $past(self_active)) |-> lo_cnt >= min_self);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ras_n(ras_n), .cas_n(cas_n),
  .done(done), .init_done(init_done), .debt_err(debt_err),
  .self_active(self_active), .min_pre(RP_CYC), .min_self(SELF_CYC)
);

// File: tb/tb_dram_refresh_sched.sv
`timescale 1ns/1ps
module tb_dram_refresh_sched;
  localparam int PAUSE = 100;
  localparam int REFI  = 250;
  localparam int CSR   = 1;
  localparam int RASW  = 8;
  localparam int RP    = 5;
  localparam int SELFW = 50;
  localparam int SRP   = 14;
  localparam int NINIT = 8;
  localparam int CMAX  = 8;
  localparam int SLP_TAB [4][2] = '{'{5, 50}, '{49, 50}, '{60, 61}, '{120, 121}};

  logic clk = 0, rst_n = 0, grant = 1, sleep_req = 1;
  logic req, ras_n, done, init_done, debt_err, self_active;
  logic [1:0] cas_n;
  int nchk = 0, nfail = 0;
  logic ras_low_seen = 0;

  always #4 clk = ~clk;

  dram_refresh_sched #(.CLK_NS(8), .PAUSE_NS(800), .REFI_NS(2000), .SELF_NS(400)) dut (
    .clk(clk), .rst_n(rst_n), .grant(grant), .sleep_req(sleep_req), .req(req),
    .ras_n(ras_n), .cas_n(cas_n), .done(done), .init_done(init_done),
    .debt_err(debt_err), .self_active(self_active));

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (ras_n === 1'b0) ras_low_seen = 1;
  endtask

  function automatic logic sel(input int which);
    case (which)
      0: return req;
      1: return ras_n;
      2: return done;
      3: return self_active;
      4: return debt_err;
      default: return cas_n[0] & cas_n[1];
    endcase
  endfunction

  task automatic wait_sig(input int which, input logic v, output int n);
    n = 0;
    do begin step(); n++; end while (sel(which) !== v && n < 4000);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int n, n2;
    repeat (3) @(negedge clk);
    chk("R1 reset req", req, 0);
    chk("R1 reset ras_n", ras_n, 1);
    chk("R1 reset cas_n", cas_n, 3);
    chk("R1 reset flags", {done, init_done, debt_err, self_active}, 0);
    rst_n = 1;
    wait_sig(0, 1, n);
    chk("R1 pause length", n, PAUSE);

    for (int i = 0; i < NINIT; i++) begin
      wait_sig(5, 0, n);
      wait_sig(1, 0, n);
      chk("R3 cas lead", n, CSR);
      wait_sig(1, 1, n);
      chk("R3 ras low width", n, RASW);
      wait_sig(2, 1, n);
      chk("R4 precharge to done", n + 1, RP);
      chk("R2 not ready during init", init_done, 0);
      chk("R2 sleep ignored in init", self_active, 0);
    end
    step();
    chk("R2 ready after last init", init_done, 1);
    sleep_req = 0;

    wait_sig(0, 1, n);
    chk("R5 first request", n, REFI + 1);
    for (int i = 0; i < 2; i++) begin
      wait_sig(0, 0, n);
      wait_sig(0, 1, n2);
      chk("R5 request spacing", n + n2, REFI);
    end

    grant = 0;
    ras_low_seen = 0;
    wait_sig(4, 1, n);
    chk("R6 debt flag timing", n, 7 * REFI - 1);
    chk("R4 no strobe without grant", ras_low_seen, 0);
    chk("R4 request held", req, 1);
    repeat (REFI) step();
    chk("R6 flag still set", debt_err, 1);
    grant = 1;
    n = 0;
    for (int i = 0; i < 200; i++) begin step(); if (done) n++; end
    chk("R6 served after saturation", n, CMAX);
    chk("R6 flag cleared", debt_err, 0);
    chk("R6 bus released", req, 0);

    grant = 0;
    wait_sig(0, 1, n);
    sleep_req = 1;
    grant = 1;
    wait_sig(1, 0, n);
    chk("R7 refresh before sleep", self_active, 0);
    wait_sig(1, 1, n);
    chk("R7 normal width first", n, RASW);
    wait_sig(1, 0, n);
    chk("R7 sleep follows", self_active, 1);
    sleep_req = 0;
    wait_sig(1, 1, n);
    chk("R8 minimum self time", n, SELFW);
    wait_sig(0, 0, n);
    chk("R9 exit precharge", n, SRP);
    wait_sig(0, 1, n);
    chk("R9 interval restarted", n, REFI + 1);

    for (int e = 0; e < 4; e++) begin
      wait_sig(2, 1, n);
      sleep_req = 1;
      wait_sig(3, 1, n);
      chk("R8 ras low in sleep", ras_n, 0);
      repeat (SLP_TAB[e][0]) step();
      sleep_req = 0;
      wait_sig(1, 1, n);
      chk("R8 self width", SLP_TAB[e][0] + n, SLP_TAB[e][1]);
      wait_sig(0, 0, n);
      chk("R9 exit hold", n, SRP);
    end

    summary();
    $finish;
  end
endmodule